// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block is one 8-bit peripheral data port with a strobe-and-acknowledge handshake. A direction input selects one of two behaviours. In the input direction a peripheral pulls the handshake line low to load its byte into a latch. The block then raises buffer-full and, once the strobe has returned high, asks the CPU for service through the interrupt request. In the output direction a CPU write loads the output latch and drives output-buffer-full (active low). The peripheral's acknowledge, taken on the same handshake line, releases that flag and can raise the interrupt request.

The handshake line comes from outside the clock domain. It passes through a two-stage synchroniser before any logic uses it. The CPU read and write strobes are active-low levels that are synchronous to the system clock. The block samples their edges against a one-cycle history. A clear pulse is issued by the surrounding logic on a mode change. It returns every flag and both latches to their idle values. The three handshake pins (strobe or acknowledge, buffer flag, interrupt) map onto the port C lines of the owning group. For the upper group these are bit 4 or 6 for the strobe or acknowledge, bit 5 or 7 for the buffer flag and bit 3 for the interrupt. For the lower group they are bits 2, 1 and 0. That mapping belongs to the surrounding wiring.

The CPU side is a plain pulse interface with no back-pressure. A second write before the peripheral acknowledges simply replaces the pending byte. The handshake flags exist so that software can avoid this.

Top module: `hs_port_channel`

## Requirements
- R1: In input direction (dir_in=1), on every clock edge where the synchronised handshake line is low, the input latch captures port_in. While that line is high the latch holds, whatever port_in does. cpu_rdata shows the input latch in input direction and the output latch in output direction.
- R2: ibf (active high) is set on the third clock edge after hs_n falls: two synchroniser stages plus one register. It is cleared on the edge where cpu_rd_n is sampled high after having been sampled low on the previous edge.
- R3: In input direction, intr is 1 after an edge exactly when these held at that edge: the synchronised line was high, ibf was 1, inte was 1, and cpu_rd_n was high on that edge and on the one before. It therefore drops one edge after cpu_rd_n falls, and it also drops when inte goes to 0.
- R4: In output direction (dir_in=0), obf_n goes low and the output latch takes cpu_wdata on the edge where cpu_wr_n is sampled high after low. On any other edge where the synchronised line is low, obf_n returns high. If both happen on the same edge, the write wins.
- R5: In output direction, intr is 1 after an edge exactly when these held at that edge: the synchronised line was high, obf_n was 1, inte was 1, and cpu_wr_n was high on that edge and the one before. It therefore drops one edge after cpu_wr_n falls.
- R6: port_out always shows the output latch. port_oe is 1 in output direction and 0 in input direction.
- R7: The channel for the direction not selected is held at its clear state. Switching direction therefore drops its flags and zeroes its latch on the next edge.
- R8: rst_n low (asynchronous), or clr high at an edge, gives ibf=0, obf_n=1, intr=0 and both latches 0x00.
- R9: If the synchronised line is still low on the edge where a read trailing edge is seen, ibf stays 1 because the strobe has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_in | input | 1 | 1 = strobed input, 0 = strobed output |
| clr | input | 1 | Synchronous clear pulse (mode change) |
| inte | input | 1 | Interrupt enable for this port |
| cpu_rd_n | input | 1 | CPU read of this port, active low |
| cpu_wr_n | input | 1 | CPU write of this port, active low |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Latched port data for the CPU |
| port_in | input | 8 | Peripheral data in |
| port_out | output | 8 | Peripheral data out |
| port_oe | output | 1 | Output enable for the port pins |
| hs_n | input | 1 | Strobe (input dir) or acknowledge (output dir), active low, asynchronous |
| ibf | output | 1 | Input buffer full, active high |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request, active high |

## Verification
The hardest situation to reach is a CPU read trailing edge that arrives while the synchronised strobe is still low. The clear and the set of the buffer flag then compete on one edge. The raw strobe has to fall about two cycles before the read rises for this to happen. The stimulus holds the read low first, lowers the strobe, and releases the read two cycles later so that the rise lands inside the synchroniser window. The same timing is applied to a write rising while the acknowledge is low. A cycle-level reference model checks every output on every clock around both collisions.

// File: rtl/hsport_pkg.sv
package hsport_pkg;
  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } hs_dir_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= RESET_VAL;
        else        pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RESET_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hs_in_chan.sv
module hs_in_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         clr,
  input  logic         stb_s,
  input  logic         inte,
  input  logic         cpu_rd_n,
  input  logic [W-1:0] port_in,
  output logic         ibf,
  output logic         intr,
  output logic [W-1:0] latch
);
  logic rd_q;
  logic hold_clr;
  logic rd_rise;

  assign hold_clr = clr | ~active;
  assign rd_rise  = ~rd_q & cpu_rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b1;
    else        rd_q <= cpu_rd_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf   <= 1'b0;
      intr  <= 1'b0;
      latch <= '0;
    end else if (hold_clr) begin
      ibf   <= 1'b0;
      intr  <= 1'b0;
      latch <= '0;
    end else begin
      if (!stb_s) begin
        ibf   <= 1'b1;
        latch <= port_in;
      end else if (rd_rise) begin
        ibf   <= 1'b0;
      end
      intr <= stb_s & ibf & inte & cpu_rd_n & rd_q;
    end
  end

  a_r2_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clr && !stb_s) |=> ibf);
  a_r3_intr_drop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && !cpu_rd_n) |=> !intr);
  a_r1_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clr && stb_s) |=> $stable(latch));
  a_r8_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ibf && !intr && latch == '0));
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         clr,
  input  logic         ack_s,
  input  logic         inte,
  input  logic         cpu_wr_n,
  input  logic [W-1:0] cpu_wdata,
  output logic         obf_n,
  output logic         intr,
  output logic [W-1:0] latch
);
  logic wr_q;
  logic hold_clr;
  logic wr_rise;

  assign hold_clr = clr | ~active;
  assign wr_rise  = ~wr_q & cpu_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= cpu_wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_n <= 1'b1;
      intr  <= 1'b0;
      latch <= '0;
    end else if (hold_clr) begin
      obf_n <= 1'b1;
      intr  <= 1'b0;
      latch <= '0;
    end else begin
      if (wr_rise) begin
        obf_n <= 1'b0;
        latch <= cpu_wdata;
      end else if (!ack_s) begin
        obf_n <= 1'b1;
      end
      intr <= ack_s & obf_n & inte & cpu_wr_n & wr_q;
    end
  end

  a_r4_obf_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clr && wr_rise) |=> (!obf_n && latch == $past(cpu_wdata)));
  a_r5_intr_drop_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !cpu_wr_n) |=> !intr);
  a_r4_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clr && !wr_rise && !ack_s) |=> obf_n);
  a_r8_out_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (obf_n && !intr && latch == '0));
endmodule

// File: rtl/hs_port_channel.sv
module hs_port_channel
  import hsport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_in,
  input  logic              clr,
  input  logic              inte,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] port_out,
  output logic              port_oe,
  input  logic              hs_n,
  output logic              ibf,
  output logic              obf_n,
  output logic              intr
);
  hs_dir_e          dir;
  logic             hs_s;
  logic             in_intr, out_intr;
  logic [DATA_W-1:0] in_latch, out_latch;

  assign dir = hs_dir_e'(dir_in);

  hs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(hs_n), .q(hs_s)
  );

  hs_in_chan #(.W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .active(dir == DIR_IN), .clr(clr),
    .stb_s(hs_s), .inte(inte), .cpu_rd_n(cpu_rd_n), .port_in(port_in),
    .ibf(ibf), .intr(in_intr), .latch(in_latch)
  );

  hs_out_chan #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .active(dir == DIR_OUT), .clr(clr),
    .ack_s(hs_s), .inte(inte), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
    .obf_n(obf_n), .intr(out_intr), .latch(out_latch)
  );

  assign intr      = (dir == DIR_IN) ? in_intr : out_intr;
  assign cpu_rdata = (dir == DIR_IN) ? in_latch : out_latch;
  assign port_out  = out_latch;
  assign port_oe   = (dir == DIR_OUT);

  a_r7_idle_side_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(dir_in) |=> (dir_in ? (obf_n && port_out == '0) : !ibf));
  a_r3_intr_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inte) |=> !intr);
endmodule

// File: tb/hs_port_channel_tb.sv
module hs_port_channel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_in = 1'b1, clr = 1'b0, inte = 1'b0;
  logic       cpu_rd_n = 1'b1, cpu_wr_n = 1'b1, hs_n = 1'b1;
  logic [7:0] cpu_wdata = 8'h00, port_in = 8'h00;
  logic [7:0] cpu_rdata, port_out;
  logic       port_oe, ibf, obf_n, intr;

  always #10 clk = ~clk;

  hs_port_channel u_dut (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .clr(clr), .inte(inte),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .port_in(port_in), .port_out(port_out),
    .port_oe(port_oe), .hs_n(hs_n), .ibf(ibf), .obf_n(obf_n), .intr(intr)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic m_h1, m_h2, m_rdp, m_wrp, m_ibf, m_iint, m_obfn, m_oint;
  logic [7:0] m_ilat, m_olat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h1 <= 1; m_h2 <= 1; m_rdp <= 1; m_wrp <= 1;
      m_ibf <= 0; m_iint <= 0; m_ilat <= 0;
      m_obfn <= 1; m_oint <= 0; m_olat <= 0;
    end else begin
      m_h1 <= hs_n; m_h2 <= m_h1; m_rdp <= cpu_rd_n; m_wrp <= cpu_wr_n;
      if (clr || !dir_in) begin
        m_ibf <= 0; m_iint <= 0; m_ilat <= 0;
      end else begin
        if (!m_h2) begin m_ibf <= 1; m_ilat <= port_in; end
        else if (!m_rdp && cpu_rd_n) m_ibf <= 0;
        m_iint <= m_h2 && m_ibf && inte && cpu_rd_n && m_rdp;
      end
      if (clr || dir_in) begin
        m_obfn <= 1; m_oint <= 0; m_olat <= 0;
      end else begin
        if (!m_wrp && cpu_wr_n) begin m_obfn <= 0; m_olat <= cpu_wdata; end
        else if (!m_h2) m_obfn <= 1;
        m_oint <= m_h2 && m_obfn && inte && cpu_wr_n && m_wrp;
      end
    end
  end

  always begin
    @(negedge clk); #8;
    if (rst_n && !done) begin
      chk("R1 rdata", cpu_rdata, dir_in ? m_ilat : m_olat);
      chk("R2 ibf", {7'b0, ibf}, {7'b0, m_ibf});
      chk("R3/R5 intr", {7'b0, intr}, {7'b0, dir_in ? m_iint : m_oint});
      chk("R4 obf_n", {7'b0, obf_n}, {7'b0, m_obfn});
      chk("R6 port_out", port_out, m_olat);
      chk("R6 port_oe", {7'b0, port_oe}, {7'b0, !dir_in});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R8 reset ibf", {7'b0, ibf}, 8'h00);
    chk("R8 reset obf_n", {7'b0, obf_n}, 8'h01);
    chk("R8 reset intr", {7'b0, intr}, 8'h00);
    rst_n = 1'b1;
    cyc(2);
    // input direction: strobe a byte
    inte = 1'b1; port_in = 8'hA5; hs_n = 1'b0;
    cyc(3); hs_n = 1'b1;
    cyc(4); port_in = 8'h3C;
    cyc(3);
    chk("R1 latch holds", cpu_rdata, 8'hA5);
    chk("R2 ibf set", {7'b0, ibf}, 8'h01);
    chk("R3 intr set", {7'b0, intr}, 8'h01);
    cpu_rd_n = 1'b0; cyc(2);
    chk("R3 intr cleared by read", {7'b0, intr}, 8'h00);
    chk("R2 ibf held during read", {7'b0, ibf}, 8'h01);
    cpu_rd_n = 1'b1; cyc(2);
    chk("R2 ibf cleared", {7'b0, ibf}, 8'h00);
    // interrupt disabled
    inte = 1'b0; port_in = 8'h77; hs_n = 1'b0; cyc(3); hs_n = 1'b1; cyc(6);
    chk("R3 no intr when disabled", {7'b0, intr}, 8'h00);
    chk("R1 second byte", cpu_rdata, 8'h77);
    inte = 1'b1; cyc(2);
    // collision: read rises while synced strobe low
    cpu_rd_n = 1'b0; cyc(2);
    port_in = 8'h91; hs_n = 1'b0; cyc(2);
    cpu_rd_n = 1'b1; cyc(1); hs_n = 1'b1; cyc(4);
    chk("R9 strobe wins over read", {7'b0, ibf}, 8'h01);
    // clear
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
    chk("R8 clr ibf", {7'b0, ibf}, 8'h00);
    chk("R8 clr latch", cpu_rdata, 8'h00);
    // output direction
    dir_in = 1'b0; cyc(3);
    chk("R6 oe in output", {7'b0, port_oe}, 8'h01);
    chk("R5 idle intr", {7'b0, intr}, 8'h01);
    cpu_wdata = 8'h5A; cpu_wr_n = 1'b0; cyc(2);
    chk("R5 intr cleared by write", {7'b0, intr}, 8'h00);
    cpu_wr_n = 1'b1; cyc(2);
    chk("R4 obf_n low", {7'b0, obf_n}, 8'h00);
    chk("R6 port_out", port_out, 8'h5A);
    hs_n = 1'b0; cyc(4);
    chk("R4 ack releases", {7'b0, obf_n}, 8'h01);
    hs_n = 1'b1; cyc(4);
    chk("R5 intr after ack", {7'b0, intr}, 8'h01);
    // collision: write rises while synced ack low
    cpu_wdata = 8'hC3; cpu_wr_n = 1'b0; cyc(1);
    hs_n = 1'b0; cyc(2); cpu_wr_n = 1'b1; cyc(1); hs_n = 1'b1; cyc(1);
    cyc(4);
    chk("R4 write wins", port_out, 8'hC3);
    // switch back: output side cleared
    dir_in = 1'b1; cyc(2);
    chk("R7 out latch cleared", port_out, 8'h00);
    chk("R7 obf_n idle", {7'b0, obf_n}, 8'h01);
    chk("R6 oe in input", {7'b0, port_oe}, 8'h00);
    cyc(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule